// File: doc/BRIEF.md
# Single-Address DMA Handshake Engine

This block is one DMA channel that moves data in fly-by fashion. Each transfer is a single bus cycle: memory is addressed from the channel's pointer, and an external peripheral sits on the data bus. The peripheral is paced by an active-low request input, an active-low acknowledge output and an active-low done pair. A direction bit picks which side the peripheral serves. When the bit is 1, memory is read and the peripheral latches the data on the acknowledge strobe. When the bit is 0, memory is written with data that the peripheral drives.

Software writes the pointer, byte count, function code, operand size and mode bits with a load pulse while the channel is stopped, and then enables the channel with a start pulse. In internal mode the channel runs back to back until the count is used up. In external mode transfers are gated by the request pin, either one transfer per request (cycle steal) or continuously while the request is held (burst). An optional filter accepts a request only after it has been seen low on two falling clock edges in a row. The channel refuses to address the on-chip dual-port memory window: it raises an error and stops without starting a bus cycle.

Top module: `flyby_dma`

## Requirements
- R1: While reset is held and after it is released, address strobe is low, acknowledge and done outputs are high (inactive), and busy and error are low.
- R2: With the direction bit at 1, each cycle is a read (bus_rw=1), and pack_n is low together with the address strobe.
- R3: With the direction bit at 0, each cycle is a write (bus_rw=0), with pack_n low together with the address strobe.
- R4: A cycle drives the pointer on bus_addr, the configured function code on bus_fc and the size code on bus_siz. The strobe rises one cycle after the address phase, and the address stays stable while the strobe is held until bus_dsack is sampled high.
- R5: With the sync bit at 1, an external request counts only after it is sampled low on two consecutive falling clock edges. With the bit at 0, a single low sample is enough.
- R6: Size code 0, 1 and 2 (3 behaves as 2) steps the pointer by 1, 2 and 4 bytes and lowers the count by the same amount after each cycle. When the count reaches zero, pdone_out_n is low for exactly one clock and the channel stops.
- R7: In cycle-steal mode each recognised request produces exactly one transfer. A request held low produces no second transfer until it has been seen high again.
- R8: In burst mode transfers repeat while the request is recognised, pause with the channel still busy when it is released, and resume when it returns.
- R9: A transfer whose address lies in [WIN_BASE, WIN_BASE+WIN_SPAN) is refused: no strobe, err goes high, and the channel stops. The next start clears err.
- R10: In internal mode the channel transfers without any activity on preq_n.
- R11: pdone_in_n low during a bus cycle ends the channel once that cycle completes. No done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads the configuration inputs while the channel is stopped |
| cfg_ptr | input | AW | Start address |
| cfg_count | input | CW | Byte count |
| cfg_fc | input | FCW | Function code for memory cycles |
| cfg_size | input | 2 | Operand size code: 0 byte, 1 word, 2 long |
| cfg_src_side | input | 1 | 1 read memory to peripheral, 0 write peripheral to memory |
| cfg_burst | input | 1 | External mode: 1 burst, 0 cycle steal |
| cfg_sync2 | input | 1 | 1 requires two falling-edge low samples of preq_n |
| cfg_ext_req | input | 1 | 1 external request pacing, 0 internal |
| start | input | 1 | Enables the channel (needs a nonzero count) |
| bus_addr | output | AW | Memory address |
| bus_fc | output | FCW | Function code |
| bus_siz | output | 2 | Size code |
| bus_as | output | 1 | Address strobe, active high |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_dsack | input | 1 | Data-size acknowledge from memory |
| preq_n | input | 1 | Peripheral request, active low |
| pack_n | output | 1 | Peripheral acknowledge and strobe, active low |
| pdone_out_n | output | 1 | One-clock terminal-count pulse, active low |
| pdone_in_n | input | 1 | Peripheral stop request, active low |
| busy | output | 1 | Channel enabled or cycle in progress |
| err | output | 1 | Dual-port window refusal |

## Verification
The bench targets the request filter at its edge: a request that covers exactly one falling edge must start nothing in two-sample mode and must start a transfer in one-sample mode. A filter wired the wrong way shows up as a missing or an extra transfer. A cycle-steal request held low for many cycles must give one transfer only; an edge detector that re-arms on the level would give several. A burst released halfway must leave the channel busy with the remaining transfers pending. A transfer that walks into the dual-port window must be refused after the legal one before it, and a design that checked only the start address would issue a strobe inside the window. A peripheral stop arriving mid-cycle must end the channel with no done pulse; the bench watches for an extra transfer or a stray pulse.

// File: rtl/flyby_dma.sv
module flyby_dma #(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int FCW = 3,
  parameter logic [AW-1:0] WIN_BASE = 'h2000,
  parameter logic [AW-1:0] WIN_SPAN = 'h1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [AW-1:0]  cfg_ptr,
  input  logic [CW-1:0]  cfg_count,
  input  logic [FCW-1:0] cfg_fc,
  input  logic [1:0]     cfg_size,
  input  logic           cfg_src_side,
  input  logic           cfg_burst,
  input  logic           cfg_sync2,
  input  logic           cfg_ext_req,
  input  logic           start,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic [1:0]     bus_siz,
  output logic           bus_as,
  output logic           bus_rw,
  input  logic           bus_dsack,
  input  logic           preq_n,
  output logic           pack_n,
  output logic           pdone_out_n,
  input  logic           pdone_in_n,
  output logic           busy,
  output logic           err
);
  typedef enum logic [1:0] {ST_IDLE, ST_S0, ST_S2, ST_S4} st_t;

  st_t            st;
  logic [AW-1:0]  ptr;
  logic [CW-1:0]  cnt;
  logic [FCW-1:0] fc_r;
  logic [1:0]     siz_r;
  logic           src_r, burst_r, sync2_r, ext_r;
  logic           run, armed, stop, done_p, err_r;
  logic           smp1, smp2;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      smp1 <= 1'b1;
      smp2 <= 1'b1;
    end else begin
      smp1 <= preq_n;
      smp2 <= smp1;
    end

  logic [2:0]    step;
  logic [CW-1:0] cnt_next;
  logic          req_low, in_win, trig, launch, refuse;

  assign step     = (siz_r == 2'd0) ? 3'd1 : (siz_r == 2'd1) ? 3'd2 : 3'd4;
  assign cnt_next = (cnt > CW'(step)) ? cnt - CW'(step) : '0;
  assign req_low  = sync2_r ? (!smp1 && !smp2) : !smp1;
  assign in_win   = (ptr >= WIN_BASE) && ((ptr - WIN_BASE) < WIN_SPAN);
  assign trig     = run && (!ext_r || (req_low && (burst_r || armed)));
  assign launch   = (st == ST_IDLE) && trig && !in_win;
  assign refuse   = (st == ST_IDLE) && trig && in_win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= ST_IDLE;
      ptr     <= '0;
      cnt     <= '0;
      fc_r    <= '0;
      siz_r   <= '0;
      src_r   <= 1'b0;
      burst_r <= 1'b0;
      sync2_r <= 1'b0;
      ext_r   <= 1'b0;
      run     <= 1'b0;
      armed   <= 1'b1;
      stop    <= 1'b0;
      done_p  <= 1'b0;
      err_r   <= 1'b0;
    end else begin
      done_p <= 1'b0;
      if (!req_low) armed <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (!run) begin
            if (cfg_load) begin
              ptr     <= cfg_ptr;
              cnt     <= cfg_count;
              fc_r    <= cfg_fc;
              siz_r   <= cfg_size;
              src_r   <= cfg_src_side;
              burst_r <= cfg_burst;
              sync2_r <= cfg_sync2;
              ext_r   <= cfg_ext_req;
            end
            if (start && cnt != '0) begin
              run   <= 1'b1;
              err_r <= 1'b0;
            end
          end else if (refuse) begin
            err_r <= 1'b1;
            run   <= 1'b0;
          end else if (launch) begin
            st   <= ST_S0;
            stop <= !pdone_in_n;
            if (ext_r && !burst_r) armed <= 1'b0;
          end
        end
        ST_S0: begin
          st <= ST_S2;
          if (!pdone_in_n) stop <= 1'b1;
        end
        ST_S2: begin
          st <= ST_S4;
          if (!pdone_in_n) stop <= 1'b1;
        end
        ST_S4: begin
          if (!pdone_in_n) stop <= 1'b1;
          if (bus_dsack) begin
            st  <= ST_IDLE;
            ptr <= ptr + AW'(step);
            cnt <= cnt_next;
            if (cnt_next == '0) begin
              run    <= 1'b0;
              done_p <= 1'b1;
            end else if (stop || !pdone_in_n) begin
              run <= 1'b0;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end

  assign bus_addr    = ptr;
  assign bus_fc      = fc_r;
  assign bus_siz     = siz_r;
  assign bus_as      = (st == ST_S2) || (st == ST_S4);
  assign bus_rw      = src_r;
  assign pack_n      = !bus_as;
  assign pdone_out_n = !done_p;
  assign busy        = run || (st != ST_IDLE);
  assign err         = err_r;
endmodule

module flyby_dma_chk #(
  parameter int AW = 24,
  parameter logic [AW-1:0] WIN_BASE = 'h2000,
  parameter logic [AW-1:0] WIN_SPAN = 'h1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_as,
  input logic          bus_dsack,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_siz,
  input logic          pdone_out_n,
  input logic          err
);
  logic [AW-1:0] stp;
  assign stp = (bus_siz == 2'd0) ? AW'(1) : (bus_siz == 2'd1) ? AW'(2) : AW'(4);

  p_wait_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as && !bus_dsack |=> bus_as);
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |=> (!bus_as || $stable(bus_addr)));
  p_done_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pdone_out_n |=> pdone_out_n);
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as) |-> bus_addr == $past(bus_addr) + $past(stp));
  p_no_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |-> !((bus_addr >= WIN_BASE) && ((bus_addr - WIN_BASE) < WIN_SPAN)));
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bus_as);
endmodule

bind flyby_dma flyby_dma_chk #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_dsack(bus_dsack),
  .bus_addr(bus_addr), .bus_siz(bus_siz), .pdone_out_n(pdone_out_n), .err(err));

// File: tb/flyby_dma_tb.sv
module flyby_dma_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] a;
    logic        rw;
    logic [1:0]  sz;
    logic [2:0]  fc;
  } xfer_t;

  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, start = 0;
  logic [23:0] cfg_ptr = 0;
  logic [15:0] cfg_count = 0;
  logic [2:0]  cfg_fc = 0;
  logic [1:0]  cfg_size = 0;
  logic cfg_src_side = 0, cfg_burst = 0, cfg_sync2 = 0, cfg_ext_req = 0;
  logic [23:0] bus_addr;
  logic [2:0]  bus_fc;
  logic [1:0]  bus_siz;
  logic bus_as, bus_rw, pack_n, pdone_out_n, busy, err;
  logic bus_dsack = 0, preq_n = 1, pdone_in_n = 1;

  int nchk = 0, nfail = 0, xfers = 0, pulses = 0, ws = 0, as_cnt = 0, dlow = 0;
  xfer_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flyby_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ptr(cfg_ptr),
    .cfg_count(cfg_count), .cfg_fc(cfg_fc), .cfg_size(cfg_size),
    .cfg_src_side(cfg_src_side), .cfg_burst(cfg_burst), .cfg_sync2(cfg_sync2),
    .cfg_ext_req(cfg_ext_req), .start(start), .bus_addr(bus_addr), .bus_fc(bus_fc),
    .bus_siz(bus_siz), .bus_as(bus_as), .bus_rw(bus_rw), .bus_dsack(bus_dsack),
    .preq_n(preq_n), .pack_n(pack_n), .pdone_out_n(pdone_out_n),
    .pdone_in_n(pdone_in_n), .busy(busy), .err(err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (bus_as) begin
      as_cnt++;
      if (as_cnt >= 2 + ws && !bus_dsack) begin
        xfer_t got;
        got = '{a: bus_addr, rw: bus_rw, sz: bus_siz, fc: bus_fc};
        xfers++;
        if (expq.size() == 0) chk(0, "R7 R9 R11 unexpected transfer", got, 0);
        else begin
          xfer_t e;
          e = expq.pop_front();
          chk(got == e, e.rw ? "R2 R4 R6 read cycle" : "R3 R4 R6 write cycle", got, e);
        end
        chk(pack_n == 1'b0, "R2 R3 ack with strobe", pack_n, 0);
        bus_dsack = 1'b1;
      end
    end else begin
      as_cnt = 0;
      bus_dsack = 1'b0;
    end
    if (!pdone_out_n) dlow++;
    else if (dlow != 0) begin
      pulses++;
      chk(dlow == 1, "R6 done width", dlow, 1);
      dlow = 0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic job(input logic [23:0] p, input logic [15:0] c, input logic [1:0] sz,
                     input logic [2:0] fc, input logic dir, input logic bu,
                     input logic s2, input logic ext);
    cfg_ptr = p; cfg_count = c; cfg_size = sz; cfg_fc = fc;
    cfg_src_side = dir; cfg_burst = bu; cfg_sync2 = s2; cfg_ext_req = ext;
    cfg_load = 1; cyc(1); cfg_load = 0;
    start = 1; cyc(1); start = 0;
  endtask

  task automatic expect_run(input logic [23:0] p, input int n, input logic [1:0] sz,
                            input logic [2:0] fc, input logic dir);
    int stp;
    stp = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int i = 0; i < n; i++)
      expq.push_back('{a: p + 24'(i * stp), rw: dir, sz: sz, fc: fc});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) cyc(1);
    cyc(3);
  endtask

  task automatic req_pulse(input int n);
    preq_n = 0; cyc(n); preq_n = 1; cyc(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int p0, q0;
    cyc(3);
    @(negedge clk);
    chk(!bus_as && pack_n && pdone_out_n && !busy && !err, "R1 in reset",
        {bus_as, pack_n, pdone_out_n, busy, err}, 5'b01100);
    rst_n = 1; cyc(2);
    @(negedge clk);
    chk(!bus_as && pack_n && pdone_out_n && !busy && !err, "R1 after reset",
        {bus_as, pack_n, pdone_out_n, busy, err}, 5'b01100);
    cyc(1);

    // R10 internal read, bytes
    p0 = pulses;
    expect_run(24'h100, 3, 2'd0, 3'd5, 1'b1);
    job(24'h100, 3, 2'd0, 3'd5, 1'b1, 0, 0, 0);
    wait_idle();
    chk(expq.size() == 0, "R10 internal run complete", expq.size(), 0);
    chk(pulses == p0 + 1, "R6 done pulse count", pulses - p0, 1);

    // R3 internal write, longs, with wait states
    ws = 2; p0 = pulses;
    expect_run(24'h400, 2, 2'd2, 3'd1, 1'b0);
    job(24'h400, 8, 2'd2, 3'd1, 1'b0, 0, 0, 0);
    wait_idle();
    chk(expq.size() == 0 && pulses == p0 + 1, "R3 R6 long write", expq.size(), 0);
    ws = 0;

    // R6 words, size code 3 behaves as long
    expect_run(24'h500, 3, 2'd1, 3'd6, 1'b1);
    job(24'h500, 6, 2'd1, 3'd6, 1'b1, 0, 0, 0);
    wait_idle();
    expect_run(24'h580, 2, 2'd3, 3'd2, 1'b0);
    job(24'h580, 8, 2'd3, 3'd2, 1'b0, 0, 0, 0);
    wait_idle();
    chk(expq.size() == 0 && !busy, "R6 word and size3 steps", expq.size(), 0);

    // R5 sync2=1: one low sample ignored, two accepted
    job(24'h700, 1, 2'd0, 3'd1, 1'b1, 0, 1, 1);
    q0 = xfers;
    req_pulse(1);
    chk(xfers == q0 && busy, "R5 single sample ignored", xfers - q0, 0);
    expect_run(24'h700, 1, 2'd0, 3'd1, 1'b1);
    req_pulse(2);
    wait_idle();
    chk(xfers == q0 + 1 && expq.size() == 0, "R5 double sample accepted", xfers - q0, 1);
    // sync2=0: one sample suffices
    job(24'h710, 1, 2'd0, 3'd1, 1'b1, 0, 0, 1);
    expect_run(24'h710, 1, 2'd0, 3'd1, 1'b1);
    q0 = xfers;
    req_pulse(1);
    wait_idle();
    chk(xfers == q0 + 1, "R5 single sample accepted", xfers - q0, 1);

    // R7 cycle steal
    job(24'h800, 4, 2'd0, 3'd3, 1'b0, 0, 0, 1);
    q0 = xfers;
    expect_run(24'h800, 2, 2'd0, 3'd3, 1'b0);
    req_pulse(3);
    req_pulse(30);
    chk(xfers == q0 + 2 && busy, "R7 one transfer per request", xfers - q0, 2);
    expect_run(24'h802, 2, 2'd0, 3'd3, 1'b0);
    req_pulse(3);
    req_pulse(3);
    wait_idle();
    chk(xfers == q0 + 4 && !busy, "R7 cycle steal finish", xfers - q0, 4);

    // R8 burst to completion
    job(24'h900, 6, 2'd0, 3'd2, 1'b1, 1, 0, 1);
    expect_run(24'h900, 6, 2'd0, 3'd2, 1'b1);
    p0 = pulses;
    preq_n = 0; wait_idle(); preq_n = 1; cyc(4);
    chk(expq.size() == 0 && pulses == p0 + 1, "R8 burst complete", expq.size(), 0);

    // R8 burst pause and resume
    job(24'hA00, 40, 2'd0, 3'd2, 1'b1, 1, 0, 1);
    expect_run(24'hA00, 40, 2'd0, 3'd2, 1'b1);
    preq_n = 0; cyc(15); preq_n = 1; cyc(8);
    q0 = expq.size();
    cyc(30);
    chk(expq.size() == q0 && q0 > 0 && q0 < 40 && busy, "R8 burst paused", expq.size(), q0);
    preq_n = 0; wait_idle(); preq_n = 1; cyc(4);
    chk(expq.size() == 0 && !busy, "R8 burst resumed", expq.size(), 0);

    // R9 window refusal at start
    q0 = xfers;
    job(24'h2000, 4, 2'd0, 3'd0, 1'b1, 0, 0, 0);
    cyc(10);
    chk(err && !busy && xfers == q0, "R9 refuse at start", {err, busy}, 2'b10);
    // R9 walking into window
    expect_run(24'h1FFE, 1, 2'd1, 3'd0, 1'b1);
    job(24'h1FFE, 6, 2'd1, 3'd0, 1'b1, 0, 0, 0);
    wait_idle();
    chk(err && xfers == q0 + 1 && expq.size() == 0, "R9 refuse on crossing", xfers - q0, 1);
    job(24'h300, 1, 2'd0, 3'd0, 1'b1, 0, 0, 0);
    expect_run(24'h300, 1, 2'd0, 3'd0, 1'b1);
    wait_idle();
    chk(!err, "R9 start clears err", err, 0);

    // R11 peripheral stop mid-cycle
    job(24'h600, 10, 2'd0, 3'd4, 1'b0, 0, 0, 0);
    expect_run(24'h600, 1, 2'd0, 3'd4, 1'b0);
    p0 = pulses; q0 = xfers;
    for (int i = 0; i < 50 && !bus_as; i++) @(negedge clk);
    pdone_in_n = 0;
    wait_idle();
    pdone_in_n = 1; cyc(10);
    chk(xfers == q0 + 1 && pulses == p0 && !busy, "R11 stop after cycle", xfers - q0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule